// File: doc/BRIEF.md
# Checking Sequence Test Sequencer

This block is a built-in test sequencer that checks a five-state Mealy machine against its state table. It owns a fixed 64-step stimulus program. Each step holds a stimulus bit, the response the table predicts, and a flag that says whether that response is compared. On each clock of a run it drives one stimulus bit into the machine under test and raises a step strobe. The machine under test advances on that edge, and its combinational response bit is judged in the same cycle.

The program has three phases. A synchronizing prefix of four zeros forces any correct machine into state A, and its responses are ignored. A distinguishing-sequence phase then identifies every state, and a transition phase exercises each of the ten table transitions, each one followed by the distinguishing sequence. The sequencer stops at the first mismatch and latches its step index, or reports pass when the last step matches. The machine under test is assumed to have no more than five states.

Top module: `chkseq_top`

## Requirements
- R1: While reset is high, and after it until the first start, `seq_pass`, `seq_fail`, `mut_step`, `mut_in` and `fail_step` are all 0.
- R2: A `start` sampled while no run is in progress clears both result flags and begins a run. During the run `mut_step` is 1 for one cycle per step, step indices rise by one per cycle from 0, and a clean run lasts exactly 64 cycles.
- R3: During step k, `mut_in` carries bit k of the stimulus string 0000_110110110_1_110_1_110_0110_0110_0110_10_0110_1110_110_1110_101_0110_101_1110 (step 0 is the leftmost bit). `mut_in` is 0 whenever `mut_step` is 0.
- R4: Responses on steps 0 to 3 (the synchronizing prefix) are never compared, so a machine under test that starts in any of its five states, or a wrong response in the prefix, does not cause a fail.
- R5: From step 4 on, every response is compared with the output of the reference table walked from state A. The table has states A=0..E=4 and is written as (next/out for input 0, next/out for input 1): A: A/1, C/1; B: C/0, A/1; C: D/0, E/0; D: A/1, B/1; E: B/0, B/0.
- R6: At the first compared mismatch, `seq_fail` becomes 1 and `fail_step` holds that step's index after the edge that ends the step. `mut_step` is 0 from then on, so the run stops.
- R7: If step 63 ends with no mismatch seen, `seq_pass` becomes 1 after that edge and the run ends.
- R8: A mismatch on the final step, 63, reports fail with index 63, and `seq_pass` stays 0. The two flags are never 1 together.
- R9: Results hold unchanged until the next accepted start, and a `start` raised during a run is ignored.
- R10: A machine whose table differs from the reference in the next state of any one of the ten transitions is reported as failing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle or finished |
| mut_out | input | 1 | Response bit of the machine under test for the current step |
| mut_in | output | 1 | Stimulus bit driven into the machine under test |
| mut_step | output | 1 | High during each step; the machine under test advances on that edge |
| seq_pass | output | 1 | Run completed with no mismatch |
| seq_fail | output | 1 | Run stopped on a mismatch |
| fail_step | output | 6 | Index of the first mismatching step |

## Verification
The end-of-program detection and the mismatch detection can fall in the same cycle, namely step 63. The bench provokes this by flipping the model's response on exactly that step and expects a fail at index 63 with pass held low. The second collision is a `start` that arrives while a step is advancing. The bench pulses it in the middle of a run and judges it by the run still lasting 64 steps and ending in pass.

// File: rtl/chkseq_pkg.sv
package chkseq_pkg;

    localparam int SEQ_LEN  = 64;
    localparam int IDX_W    = $clog2(SEQ_LEN);
    localparam int SYNC_LEN = 4;

    typedef enum logic [2:0] {
        MS_A = 3'd0,
        MS_B = 3'd1,
        MS_C = 3'd2,
        MS_D = 3'd3,
        MS_E = 3'd4
    } ref_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_DONE = 2'd2
    } seq_phase_e;

    typedef struct packed {
        logic stim;
        logic expect_bit;
        logic cmp_en;
    } step_entry_t;

    // Step 0 is the leftmost bit: prefix, state identification, transition checks.
    localparam logic [SEQ_LEN-1:0] STIM_PATTERN =
        64'b0000_110110110_1_110_1_110_0110_0110_0110_10_0110_1110_110_1110_101_0110_101_1110;

    function automatic logic stim_at(input int k);
        return STIM_PATTERN[SEQ_LEN-1-k];
    endfunction

    function automatic ref_state_e ref_next(input ref_state_e s, input logic x);
        ref_state_e n;
        case (s)
            MS_A:    n = x ? MS_C : MS_A;
            MS_B:    n = x ? MS_A : MS_C;
            MS_C:    n = x ? MS_E : MS_D;
            MS_D:    n = x ? MS_B : MS_A;
            default: n = MS_B;
        endcase
        return n;
    endfunction

    function automatic logic ref_out(input ref_state_e s, input logic x);
        logic o;
        case (s)
            MS_A:    o = 1'b1;
            MS_B:    o = x;
            MS_C:    o = 1'b0;
            MS_D:    o = 1'b1;
            default: o = 1'b0;
        endcase
        return o;
    endfunction

    // Expected response of step k, stored at bit k; prefix bits left at zero.
    function automatic logic [SEQ_LEN-1:0] build_expect();
        logic [SEQ_LEN-1:0] v;
        ref_state_e         s;
        v = '0;
        s = MS_A;
        for (int k = SYNC_LEN; k < SEQ_LEN; k++) begin
            v[k] = ref_out(s, stim_at(k));
            s    = ref_next(s, stim_at(k));
        end
        return v;
    endfunction

    localparam logic [SEQ_LEN-1:0] EXPECT_PATTERN = build_expect();

endpackage

// File: rtl/chkseq_rom.sv
module chkseq_rom
    import chkseq_pkg::*;
#(
    parameter int DEPTH = SEQ_LEN,
    parameter int AW    = IDX_W
) (
    input  logic [AW-1:0] addr,
    output step_entry_t   entry
);

    step_entry_t table_w [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            assign table_w[g] = '{
                stim:       STIM_PATTERN[SEQ_LEN-1-g],
                expect_bit: EXPECT_PATTERN[g],
                cmp_en:     (g >= SYNC_LEN)
            };
        end
    endgenerate

    assign entry = table_w[addr];

endmodule

// File: rtl/chkseq_cmp.sv
module chkseq_cmp
    import chkseq_pkg::*;
(
    input  step_entry_t entry,
    input  logic        active,
    input  logic        resp,
    output logic        mismatch,
    output logic        drive_bit
);

    always_comb begin
        drive_bit = active & entry.stim;
        mismatch  = active & entry.cmp_en & (resp != entry.expect_bit);
    end

endmodule

// File: rtl/chkseq_ctrl.sv
module chkseq_ctrl
    import chkseq_pkg::*;
#(
    parameter int DEPTH = SEQ_LEN,
    parameter int AW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mismatch,
    output logic [AW-1:0] step_idx,
    output logic          running,
    output logic          pass_q,
    output logic          fail_q,
    output logic [AW-1:0] fail_idx_q
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    seq_phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= SQ_IDLE;
            step_idx   <= '0;
            pass_q     <= 1'b0;
            fail_q     <= 1'b0;
            fail_idx_q <= '0;
        end else begin
            case (phase_q)
                SQ_RUN: begin
                    if (mismatch) begin
                        fail_q     <= 1'b1;
                        fail_idx_q <= step_idx;
                        phase_q    <= SQ_DONE;
                    end else if (step_idx == LAST_IDX) begin
                        pass_q  <= 1'b1;
                        phase_q <= SQ_DONE;
                    end else begin
                        step_idx <= step_idx + 1'b1;
                    end
                end
                default: begin
                    if (start) begin
                        phase_q    <= SQ_RUN;
                        step_idx   <= '0;
                        pass_q     <= 1'b0;
                        fail_q     <= 1'b0;
                        fail_idx_q <= '0;
                    end
                end
            endcase
        end
    end

    assign running = (phase_q == SQ_RUN);

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pass_q && fail_q)); // R8

    AST_FIRST_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        running && mismatch |=> fail_q && !running && fail_idx_q == $past(step_idx)); // R6

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        running && !mismatch && step_idx != LAST_IDX |=> running && step_idx == $past(step_idx) + 1'b1); // R2

    AST_PASS_AT_END: assert property (@(posedge clk) disable iff (rst)
        running && !mismatch && step_idx == LAST_IDX |=> pass_q && !running); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !running && !start |=> $stable(pass_q) && $stable(fail_q) && $stable(fail_idx_q)); // R9

endmodule

// File: rtl/chkseq_top.sv
module chkseq_top
    import chkseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mut_out,
    output logic             mut_in,
    output logic             mut_step,
    output logic             seq_pass,
    output logic             seq_fail,
    output logic [IDX_W-1:0] fail_step
);

    logic [IDX_W-1:0] step_idx;
    logic             running;
    logic             mismatch;
    step_entry_t      entry;

    chkseq_rom #(.DEPTH(SEQ_LEN), .AW(IDX_W)) rom_i (
        .addr  (step_idx),
        .entry (entry)
    );

    chkseq_cmp cmp_i (
        .entry     (entry),
        .active    (running),
        .resp      (mut_out),
        .mismatch  (mismatch),
        .drive_bit (mut_in)
    );

    chkseq_ctrl #(.DEPTH(SEQ_LEN), .AW(IDX_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mismatch   (mismatch),
        .step_idx   (step_idx),
        .running    (running),
        .pass_q     (seq_pass),
        .fail_q     (seq_fail),
        .fail_idx_q (fail_step)
    );

    assign mut_step = running;

    AST_PREFIX_MASKED: assert property (@(posedge clk) disable iff (rst)
        mut_step && step_idx < IDX_W'(SYNC_LEN) |-> !mismatch); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !mut_step |-> !mut_in); // R3

endmodule

// File: tb/chkseq_top_tb_top.sv
`timescale 1ns/1ps
module chkseq_top_tb_top;

    localparam logic [63:0] TB_STIM =
        64'b0000_110110110_1_110_1_110_0110_0110_0110_10_0110_1110_110_1110_101_0110_101_1110;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mut_out;
    logic       mut_in;
    logic       mut_step;
    logic       seq_pass;
    logic       seq_fail;
    logic [5:0] fail_step;

    int n_chk = 0;
    int n_fail = 0;

    // Reference table, states A=0..E=4, indexed [state][input].
    int g_next [5][2] = '{'{0, 2}, '{2, 0}, '{3, 4}, '{0, 1}, '{1, 1}};
    int g_out  [5][2] = '{'{1, 1}, '{0, 1}, '{0, 0}, '{1, 1}, '{0, 0}};
    int f_next [5][2];
    int f_out  [5][2];
    int init_state = 0;
    int fault_step = -1;
    int m_state = 0;
    int cnt = 0;

    typedef struct {
        bit    exp_pass;
        int    exp_idx;
        int    exp_len;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    chkseq_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mut_out   (mut_out),
        .mut_in    (mut_in),
        .mut_step  (mut_step),
        .seq_pass  (seq_pass),
        .seq_fail  (seq_fail),
        .fail_step (fail_step)
    );

    // Behavioural machine under test, with optional table and response faults.
    always_comb mut_out = logic'(f_out[m_state][mut_in] != 0) ^ logic'(cnt == fault_step);

    always @(posedge clk) begin
        if (start && !mut_step) begin
            m_state <= init_state;
            cnt     <= 0;
        end else if (mut_step) begin
            m_state <= f_next[m_state][mut_in];
            cnt     <= cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void predict(output bit p, output int idx);
        int sf;
        int sg;
        int fo;
        sf  = init_state;
        sg  = 0;
        idx = -1;
        for (int k = 0; k < 64; k++) begin
            logic x;
            x  = TB_STIM[63-k];
            fo = f_out[sf][x] ^ ((k == fault_step) ? 1 : 0);
            if (k >= 4 && idx < 0 && fo != g_out[sg][x]) idx = k;
            sf = f_next[sf][x];
            if (k >= 4) sg = g_next[sg][x];
        end
        p = (idx < 0);
    endfunction

    task automatic push_expect(input string tag);
        exp_t e;
        bit   p;
        int   idx;
        predict(p, idx);
        e.exp_pass = p;
        e.exp_idx  = p ? 0 : idx;
        e.exp_len  = p ? 64 : idx + 1;
        e.tag      = tag;
        sb_q.push_back(e);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        while (mut_step) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_case(input int init, input int fstep, input string tag);
        init_state = init;
        fault_step = fstep;
        push_expect(tag);
        pulse_start();
        chk(mut_step && !seq_pass && !seq_fail, "R2", "run started with cleared results",
            {29'd0, mut_step, seq_pass, seq_fail}, 4);
        wait_done();
    endtask

    // Monitor: per-step stimulus check and end-of-run scoreboard compare.
    initial begin
        bit   prev_step = 1'b0;
        int   run_len = 0;
        int   stim_bad = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (mut_step) begin
                run_len++;
                if (cnt < 64 && mut_in !== TB_STIM[63-cnt]) stim_bad++;
            end
            if (prev_step && !mut_step) begin
                e = sb_q.pop_front();
                chk(seq_pass == e.exp_pass, e.tag, "pass flag", int'(seq_pass), int'(e.exp_pass));
                chk(seq_fail == !e.exp_pass, e.tag, "fail flag", int'(seq_fail), int'(!e.exp_pass));
                chk(int'(fail_step) == e.exp_idx, e.tag, "fail step", int'(fail_step), e.exp_idx);
                chk(run_len == e.exp_len, "R2", "run length", run_len, e.exp_len);
                chk(stim_bad == 0, "R3", "stimulus bits", stim_bad, 0);
                run_len  = 0;
                stim_bad = 0;
            end
            prev_step = mut_step;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        f_next = g_next;
        f_out  = g_out;
        repeat (4) @(negedge clk);
        chk(!seq_pass && !seq_fail && !mut_step && !mut_in && fail_step == 6'd0, "R1",
            "outputs in reset", {28'd0, seq_pass, seq_fail, mut_step, mut_in}, 0);
        @(negedge clk) rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!seq_pass && !seq_fail && !mut_step && !mut_in, "R1", "outputs idle after reset",
            {28'd0, seq_pass, seq_fail, mut_step, mut_in}, 0);

        // Correct machine from every start state: prefix synchronizes (R4), pass (R5, R7).
        for (int s = 0; s < 5; s++) run_case(s, -1, "R4_R7");

        // Wrong responses inside the prefix are ignored (R4).
        run_case(3, 1, "R4");
        run_case(0, 3, "R4");

        // Response faults after the prefix (R5, R6).
        run_case(0, 4, "R6");
        run_case(2, 30, "R5_R6");
        chk(seq_fail && fail_step == 6'd30, "R6", "fail step latched", int'(fail_step), 30);

        // Mismatch on the final step: fail wins over pass (R8).
        run_case(4, 63, "R8");
        chk(seq_fail && !seq_pass && fail_step == 6'd63, "R8", "final-step fail",
            int'(fail_step) + (seq_pass ? 100 : 0), 63);

        // Results hold while idle (R9).
        repeat (20) @(negedge clk);
        chk(seq_fail && fail_step == 6'd63 && !mut_step, "R9", "fail result held",
            int'(fail_step), 63);

        // Start during a run is ignored (R9).
        init_state = 1;
        fault_step = -1;
        push_expect("R9");
        pulse_start();
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        chk(seq_pass && !seq_fail, "R9", "pass result held", int'(seq_pass), 1);

        // Single next-state faults on each of the ten transitions (R10).
        for (int s = 0; s < 5; s++) begin
            for (int x = 0; x < 2; x++) begin
                f_next = g_next;
                f_next[s][x] = (g_next[s][x] + 1) % 5;
                run_case(0, -1, "R10");
                chk(seq_fail && !seq_pass, "R10", "transition fault detected",
                    int'(seq_fail), 1);
            end
        end
        f_next = g_next;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule